// File: doc/BRIEF.md
# Double-Buffered Vector Operand Streamer

The streamer feeds one pipelined arithmetic unit from a wide memory port that moves eight words per access. It keeps two operand streams (X and Y) and one result stream (Z) moving through three ping-pong buffers. Each buffer has two halves of one eight-word octet, so one half can fill or drain against memory while the arithmetic unit works on the other half.

In vector mode a single start pulse loads three base addresses, one element stride and an element count. From then on the block computes every octet address itself. It fetches operand octets as soon as a buffer half is free, which is look-ahead, and writes result octets back. The last octet may hold fewer than eight elements.

In scalar mode the block handles one element. It reads operands at effective addresses given from outside and stores one result word. Instead of reading memory, it can take either operand from the most recent result the block has accepted. All memory traffic shares one request/acknowledge port.

Top module: `octet_streamer`

## Requirements
- R1: After reset, busy, done, mem_req, op_valid and res_ready are all low.
- R2: Every memory access moves one octet, and mem_stride equals the element stride. For each stream, octet k is read or written at base + 8·k·stride. A run of n elements makes ceil(n/8) reads on X, ceil(n/8) reads on Y and ceil(n/8) writes on Z. Lane i of mem_rdata/mem_wdata is bits [16i+15:16i] (W=16) and belongs to address addr + i·stride.
- R3: Operand pairs reach the arithmetic unit in element order, one pair per op_valid/op_ready handshake. Pair k is (word at xbase+k·stride, word at ybase+k·stride). The pair holds steady while op_ready is low.
- R4: Result k is stored at zbase + k·stride. Bit i of mem_wmask enables lane i. In the final octet, only lanes below the number of remaining elements are enabled, so memory past the last element is left unchanged.
- R5: Operand octets are fetched ahead of use. With the arithmetic unit stalled and at least 16 elements, both halves of X and of Y are filled, giving four reads, before any pair is consumed.
- R6: When the port is free, a full Z half is written before any fetch. Otherwise the operand stream that holds fewer buffered words is fetched, and X wins a tie.
- R7: Once raised, mem_req stays high with mem_addr and mem_we unchanged until mem_ack.
- R8: A scalar start reads lane 0 of the octet at s_xaddr and of the octet at s_yaddr. It stores the one result at s_zaddr with only mask bit 0 set.
- R9: When s_xfwd or s_yfwd is set, that operand is the last result the block accepted, and no memory read is made for it.
- R10: done is a one-cycle pulse after the acknowledge of the final Z write. busy is low in the cycle where done is high.
- R11: Start pulses are ignored while busy, and a vector start with count 0 is ignored. When v_start and s_start arrive together, s_start is ignored.
- R12: res_ready is high only while results of the current run are still owed and a Z half has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| v_start | input | 1 | Start a vector run |
| v_xbase | input | AW | First X element address |
| v_ybase | input | AW | First Y element address |
| v_zbase | input | AW | First Z element address |
| v_stride | input | AW | Element stride, in words |
| v_count | input | CW | Number of elements |
| s_start | input | 1 | Start a scalar operation |
| s_xfwd | input | 1 | Take X from the last result |
| s_yfwd | input | 1 | Take Y from the last result |
| s_xaddr | input | AW | Scalar X effective address |
| s_yaddr | input | AW | Scalar Y effective address |
| s_zaddr | input | AW | Scalar result address |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Address of lane 0 |
| mem_stride | output | AW | Address distance between lanes |
| mem_wdata | output | 8·W | Write octet |
| mem_wmask | output | 8 | Per-lane write enable |
| mem_rdata | input | 8·W | Read octet, valid with mem_ack |
| mem_ack | input | 1 | Request completed this cycle |
| op_valid | output | 1 | Operand pair available |
| op_ready | input | 1 | Arithmetic unit takes the pair |
| op_x | output | W | X operand |
| op_y | output | W | Y operand |
| res_valid | input | 1 | Result offered |
| res_ready | output | 1 | Result accepted |
| res_data | input | W | Result word |

## Verification
Two kinds of event can fall in the same cycle. First, a result can enter Z in the same cycle that a pair leaves X and Y. Second, a full Z half can compete for the one port with an X or Y half that has drained. Both are provoked by sweeping counts from 1 to 17 and strides from 1 to 3. During the sweep, the memory model delays each acknowledge by a random number of cycles, and the model arithmetic unit accepts operands and offers results at random times. Each case is judged against arithmetic expectations in the bench. The expected octet addresses are derived from base, stride and octet index. Every pair is compared with the memory image, and every stored word with the sum of its pair. Read and write counts must equal ceil(n/8) per stream, and words just past the last element must be untouched.

// File: rtl/osv_pkg.sv
// Shared constants and types for the octet streamer.
// Assumes an octet of eight words, fixed by the memory port's transfer size.
package osv_pkg;
    localparam int OCT = 8;

    typedef enum logic [1:0] {
        GR_NONE = 2'd0,
        GR_X    = 2'd1,
        GR_Y    = 2'd2,
        GR_Z    = 2'd3
    } grant_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mode_e;
endpackage

// File: rtl/osv_inbuf.sv
// Operand ping-pong buffer: two octet halves. The memory side fills the half
// at wr_sel; the arithmetic side pops words from the half at rd_sel.
// Assumes fill_en is only raised when can_fill is high and pop only when avail.
module osv_inbuf
    import osv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [OCT*W-1:0]  fill_data,
    input  logic [3:0]        fill_cnt,
    input  logic              pop,
    output logic [W-1:0]      out_word,
    output logic              avail,
    output logic              can_fill,
    output logic [4:0]        level
);
    logic [W-1:0] data_q [0:1][0:OCT-1];
    logic [3:0]   cnt_q  [0:1];
    logic [1:0]   full_q;
    logic         wr_sel_q, rd_sel_q;
    logic [2:0]   rd_idx_q;
    logic         half_end;

    // Purpose: capture an arriving octet into the half being filled.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int i = 0; i < OCT; i++) begin
                data_q[wr_sel_q][i] <= fill_data[i*W +: W];
            end
        end
    end

    assign half_end = ({1'b0, rd_idx_q} + 4'd1) == cnt_q[rd_sel_q];

    // Purpose: track which halves are full and the position of the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q   <= 2'b00;
            wr_sel_q <= 1'b0;
            rd_sel_q <= 1'b0;
            rd_idx_q <= 3'd0;
            cnt_q[0] <= 4'd0;
            cnt_q[1] <= 4'd0;
        end else begin
            if (fill_en) begin
                full_q[wr_sel_q] <= 1'b1;
                cnt_q[wr_sel_q]  <= fill_cnt;
                wr_sel_q         <= ~wr_sel_q;
            end
            if (pop && full_q[rd_sel_q]) begin
                if (half_end) begin
                    full_q[rd_sel_q] <= 1'b0;
                    rd_sel_q         <= ~rd_sel_q;
                    rd_idx_q         <= 3'd0;
                end else begin
                    rd_idx_q <= rd_idx_q + 3'd1;
                end
            end
        end
    end

    // Purpose: present the head word, flags and the number of words held.
    always_comb begin
        out_word = data_q[rd_sel_q][rd_idx_q];
        avail    = full_q[rd_sel_q];
        can_fill = !full_q[wr_sel_q];
        level    = {1'b0, full_q[0] ? cnt_q[0] : 4'd0}
                 + {1'b0, full_q[1] ? cnt_q[1] : 4'd0}
                 - {2'b00, avail ? rd_idx_q : 3'd0};
    end
endmodule

// File: rtl/osv_outbuf.sv
// Result ping-pong buffer: two octet halves. Results are pushed one word at a
// time. A half closes after eight words or on the last word of the run. The
// memory side drains the half at rd_sel.
// Assumes push only when wr_ok and drain only when rd_full.
module osv_outbuf
    import osv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [W-1:0]      push_data,
    input  logic              push_last,
    input  logic              drain,
    output logic              wr_ok,
    output logic              rd_full,
    output logic [OCT*W-1:0]  rd_data,
    output logic [3:0]        rd_cnt
);
    logic [W-1:0] data_q [0:1][0:OCT-1];
    logic [3:0]   cnt_q  [0:1];
    logic [1:0]   full_q;
    logic         wr_sel_q, rd_sel_q;
    logic [2:0]   wr_idx_q;

    // Purpose: write an accepted result into the open half.
    always_ff @(posedge clk) begin
        if (push) begin
            data_q[wr_sel_q][wr_idx_q] <= push_data;
        end
    end

    // Purpose: close halves on the eighth or last word, and free them on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q   <= 2'b00;
            wr_sel_q <= 1'b0;
            rd_sel_q <= 1'b0;
            wr_idx_q <= 3'd0;
            cnt_q[0] <= 4'd0;
            cnt_q[1] <= 4'd0;
        end else begin
            if (push) begin
                if (wr_idx_q == 3'd7 || push_last) begin
                    full_q[wr_sel_q] <= 1'b1;
                    cnt_q[wr_sel_q]  <= {1'b0, wr_idx_q} + 4'd1;
                    wr_sel_q         <= ~wr_sel_q;
                    wr_idx_q         <= 3'd0;
                end else begin
                    wr_idx_q <= wr_idx_q + 3'd1;
                end
            end
            if (drain && full_q[rd_sel_q]) begin
                full_q[rd_sel_q] <= 1'b0;
                rd_sel_q         <= ~rd_sel_q;
            end
        end
    end

    // Purpose: expose the drain half as one octet with its word count.
    always_comb begin
        for (int i = 0; i < OCT; i++) begin
            rd_data[i*W +: W] = data_q[rd_sel_q][i];
        end
        rd_cnt  = cnt_q[rd_sel_q];
        rd_full = full_q[rd_sel_q];
        wr_ok   = !full_q[wr_sel_q];
    end
endmodule

// File: rtl/osv_agen.sv
// Octet address generator for one stream. It holds the current octet address
// and the number of elements still to move. step advances by eight elements.
// Assumes step is only raised while more is high.
module osv_agen #(
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] stride,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [3:0]    oct_cnt,
    output logic          more
);
    logic [AW-1:0] addr_q;
    logic [CW-1:0] rem_q;

    // Purpose: elements carried by the current octet (eight, or the remainder).
    always_comb begin
        oct_cnt = (rem_q >= CW'(8)) ? 4'd8 : rem_q[3:0];
        more    = rem_q != '0;
        addr    = addr_q;
    end

    // Purpose: load at run start and advance one octet per completed access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= base;
            rem_q  <= count;
        end else if (step) begin
            addr_q <= addr_q + (stride << 3);
            rem_q  <= rem_q - {{(CW-4){1'b0}}, oct_cnt};
        end
    end
endmodule

// File: rtl/osv_arb.sv
// Port arbiter. A full result half goes first. Otherwise the operand stream
// with fewer buffered words is chosen, and X wins a tie.
// Assumes the caller samples the grant only while the port is free.
module osv_arb
    import osv_pkg::*;
(
    input  logic       z_want,
    input  logic       x_want,
    input  logic       y_want,
    input  logic [4:0] x_level,
    input  logic [4:0] y_level,
    output grant_e     grant
);
    // Purpose: fixed store-first priority, then the emptier operand stream.
    always_comb begin
        if (z_want)                grant = GR_Z;
        else if (x_want && y_want) grant = (y_level < x_level) ? GR_Y : GR_X;
        else if (x_want)           grant = GR_X;
        else if (y_want)           grant = GR_Y;
        else                       grant = GR_NONE;
    end
endmodule

// File: rtl/octet_streamer.sv
// Double-buffered operand/result streamer between an octet-wide memory port
// and one arithmetic unit. A vector run moves v_count elements. A scalar run
// is a one-element run whose operands may be taken from the last result.
// Assumes one memory request is outstanding at a time, and that the arithmetic
// unit returns exactly one result per operand pair, in order.
module octet_streamer
    import osv_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_start,
    input  logic [AW-1:0]     v_xbase,
    input  logic [AW-1:0]     v_ybase,
    input  logic [AW-1:0]     v_zbase,
    input  logic [AW-1:0]     v_stride,
    input  logic [CW-1:0]     v_count,
    input  logic              s_start,
    input  logic              s_xfwd,
    input  logic              s_yfwd,
    input  logic [AW-1:0]     s_xaddr,
    input  logic [AW-1:0]     s_yaddr,
    input  logic [AW-1:0]     s_zaddr,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [AW-1:0]     mem_stride,
    output logic [OCT*W-1:0]  mem_wdata,
    output logic [OCT-1:0]    mem_wmask,
    input  logic [OCT*W-1:0]  mem_rdata,
    input  logic              mem_ack,
    output logic              op_valid,
    input  logic              op_ready,
    output logic [W-1:0]      op_x,
    output logic [W-1:0]      op_y,
    input  logic              res_valid,
    output logic              res_ready,
    input  logic [W-1:0]      res_data
);
    localparam int DW = OCT * W;

    mode_e         mode_q;
    grant_e        port_gnt_q, grant;
    logic          port_busy_q, done_q;
    logic [AW-1:0] stride_q;
    logic [CW-1:0] res_rem_q;
    logic [W-1:0]  z_last_q;

    logic start_v, start_s, start_any, port_ack;
    logic x_step, y_step, z_step, pop, push;
    logic x_fill, y_fill;
    logic [DW-1:0] x_fill_data, y_fill_data;
    logic [3:0]    x_fill_cnt, y_fill_cnt;

    logic [AW-1:0] x_addr, y_addr, z_addr;
    logic [3:0]    x_oct, y_oct, z_oct;
    logic          x_more, y_more, z_more;
    logic          x_avail, y_avail, x_can, y_can;
    logic [4:0]    x_lvl, y_lvl;
    logic          z_wr_ok, z_rd_full;
    logic [3:0]    z_rd_cnt;

    // Purpose: decode start pulses that are accepted only while idle.
    always_comb begin
        start_v   = (mode_q == ST_IDLE) && v_start && (v_count != '0);
        start_s   = (mode_q == ST_IDLE) && s_start && !v_start;
        start_any = start_v || start_s;
        port_ack  = port_busy_q && mem_ack;
        x_step    = port_ack && (port_gnt_q == GR_X);
        y_step    = port_ack && (port_gnt_q == GR_Y);
        z_step    = port_ack && (port_gnt_q == GR_Z);
        pop       = op_valid && op_ready;
        push      = res_valid && res_ready;
    end

    // Purpose: choose each operand buffer's fill source (memory or last result).
    always_comb begin
        x_fill      = x_step || (start_s && s_xfwd);
        y_fill      = y_step || (start_s && s_yfwd);
        x_fill_data = x_step ? mem_rdata : {{(DW-W){1'b0}}, z_last_q};
        y_fill_data = y_step ? mem_rdata : {{(DW-W){1'b0}}, z_last_q};
        x_fill_cnt  = x_step ? x_oct : 4'd1;
        y_fill_cnt  = y_step ? y_oct : 4'd1;
    end

    osv_agen #(.AW(AW), .CW(CW)) u_agen_x (
        .clk(clk), .rst_n(rst_n), .load(start_any),
        .base(start_v ? v_xbase : s_xaddr),
        .count(start_v ? v_count : CW'(s_xfwd ? 0 : 1)),
        .stride(stride_q), .step(x_step),
        .addr(x_addr), .oct_cnt(x_oct), .more(x_more)
    );

    osv_agen #(.AW(AW), .CW(CW)) u_agen_y (
        .clk(clk), .rst_n(rst_n), .load(start_any),
        .base(start_v ? v_ybase : s_yaddr),
        .count(start_v ? v_count : CW'(s_yfwd ? 0 : 1)),
        .stride(stride_q), .step(y_step),
        .addr(y_addr), .oct_cnt(y_oct), .more(y_more)
    );

    osv_agen #(.AW(AW), .CW(CW)) u_agen_z (
        .clk(clk), .rst_n(rst_n), .load(start_any),
        .base(start_v ? v_zbase : s_zaddr),
        .count(start_v ? v_count : CW'(1)),
        .stride(stride_q), .step(z_step),
        .addr(z_addr), .oct_cnt(z_oct), .more(z_more)
    );

    osv_inbuf #(.W(W)) u_xbuf (
        .clk(clk), .rst_n(rst_n), .fill_en(x_fill), .fill_data(x_fill_data),
        .fill_cnt(x_fill_cnt), .pop(pop), .out_word(op_x), .avail(x_avail),
        .can_fill(x_can), .level(x_lvl)
    );

    osv_inbuf #(.W(W)) u_ybuf (
        .clk(clk), .rst_n(rst_n), .fill_en(y_fill), .fill_data(y_fill_data),
        .fill_cnt(y_fill_cnt), .pop(pop), .out_word(op_y), .avail(y_avail),
        .can_fill(y_can), .level(y_lvl)
    );

    osv_outbuf #(.W(W)) u_zbuf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(res_data),
        .push_last(res_rem_q == CW'(1)), .drain(z_step),
        .wr_ok(z_wr_ok), .rd_full(z_rd_full), .rd_data(mem_wdata),
        .rd_cnt(z_rd_cnt)
    );

    osv_arb u_arb (
        .z_want(z_rd_full),
        .x_want(x_more && x_can),
        .y_want(y_more && y_can),
        .x_level(x_lvl), .y_level(y_lvl),
        .grant(grant)
    );

    // Purpose: hold one port transaction from grant to acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_busy_q <= 1'b0;
            port_gnt_q  <= GR_NONE;
        end else if (port_busy_q) begin
            if (mem_ack) begin
                port_busy_q <= 1'b0;
                port_gnt_q  <= GR_NONE;
            end
        end else if (mode_q == ST_RUN && grant != GR_NONE) begin
            port_busy_q <= 1'b1;
            port_gnt_q  <= grant;
        end
    end

    // Purpose: run state, stride, owed-result count, last result and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= ST_IDLE;
            done_q    <= 1'b0;
            stride_q  <= '0;
            res_rem_q <= '0;
            z_last_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (push) begin
                res_rem_q <= res_rem_q - CW'(1);
                z_last_q  <= res_data;
            end
            if (start_any) begin
                mode_q    <= ST_RUN;
                stride_q  <= start_v ? v_stride : AW'(1);
                res_rem_q <= start_v ? v_count : CW'(1);
            end else if (mode_q == ST_RUN && !z_more && !port_busy_q) begin
                mode_q <= ST_IDLE;
                done_q <= 1'b1;
            end
        end
    end

    // Purpose: drive the port and the arithmetic-side handshakes.
    always_comb begin
        busy       = mode_q == ST_RUN;
        done       = done_q;
        mem_req    = port_busy_q;
        mem_we     = port_gnt_q == GR_Z;
        mem_stride = stride_q;
        case (port_gnt_q)
            GR_X:    mem_addr = x_addr;
            GR_Y:    mem_addr = y_addr;
            GR_Z:    mem_addr = z_addr;
            default: mem_addr = '0;
        endcase
        for (int i = 0; i < OCT; i++) begin
            mem_wmask[i] = mem_we && (4'(i) < z_rd_cnt);
        end
        op_valid  = x_avail && y_avail;
        res_ready = busy && (res_rem_q != '0) && z_wr_ok;
    end

    // z_oct is used only for pacing in the generator; tie it into a reduction.
    logic unused_z_oct;
    assign unused_z_oct = ^z_oct;
endmodule

// File: rtl/osv_check.sv
// Assertion checker for octet_streamer, attached with bind.
// Assumes the port transaction flag and the Z drain-half flag are visible by name.
module osv_check #(
    parameter int W  = 16,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wmask,
    input logic          op_valid,
    input logic          op_ready,
    input logic [W-1:0]  op_x,
    input logic [W-1:0]  op_y,
    input logic          res_ready,
    input logic          port_busy_q,
    input logic          z_rd_full
);
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r6_store_first: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !port_busy_q && z_rd_full |=> mem_req && mem_we);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r12_res_gate: assert property (@(posedge clk) disable iff (!rst_n)
        res_ready |-> busy);

    a_r3_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable(op_x) && $stable(op_y));

    a_r4_lane0_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wmask[0]);
endmodule

bind octet_streamer osv_check #(.W(W), .AW(AW)) u_osv_check (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wmask(mem_wmask),
    .op_valid(op_valid), .op_ready(op_ready), .op_x(op_x), .op_y(op_y),
    .res_ready(res_ready), .port_busy_q(port_busy_q), .z_rd_full(z_rd_full)
);

// File: tb/tb_octet_streamer.sv
module tb_octet_streamer;
    localparam int W = 16, AW = 16, CW = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic v_start = 0, s_start = 0, s_xfwd = 0, s_yfwd = 0;
    logic [AW-1:0] v_xbase = 0, v_ybase = 0, v_zbase = 0, v_stride = 0;
    logic [CW-1:0] v_count = 0;
    logic [AW-1:0] s_xaddr = 0, s_yaddr = 0, s_zaddr = 0;
    logic busy, done, mem_req, mem_we, op_valid, res_ready;
    logic [AW-1:0] mem_addr, mem_stride;
    logic [8*W-1:0] mem_wdata, mem_rdata = '0;
    logic [7:0] mem_wmask;
    logic mem_ack = 0, op_ready = 0, res_valid = 0;
    logic [W-1:0] op_x, op_y, res_data = 0;

    octet_streamer #(.W(W), .AW(AW), .CW(CW)) dut (.*);

    always #4 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ival(input int a);
        return 16'((a & 1023) * 37 + 11);
    endfunction

    logic [15:0] mm [0:1023];
    logic [15:0] ex_x [0:63];
    logic [15:0] ex_y [0:63];
    logic [15:0] rq [0:255];
    int qh, qt, pair_k, rds, wrs, xo, yo, zo, first_rd, done_cnt = 0;
    int exb, eyb, ezb, es;
    bit au_en = 1;
    logic [15:0] lfsr = 16'hACE1, last_res = 0;
    int wait_n = 0;
    bit req_seen = 0;
    logic [AW-1:0] held_addr;

    task automatic init_mem();
        for (int a = 0; a < 1024; a++) mm[a] = ival(a);
    endtask

    // Memory, arithmetic-unit and done models, all acting at the falling edge.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (done) begin
            done_cnt++;
            chk(!busy, "R10 busy low with done", busy, 0);
        end
        if (mem_ack) mem_ack = 0;
        else if (mem_req) begin
            if (!req_seen) begin
                req_seen = 1; held_addr = mem_addr; wait_n = lfsr[1:0] % 3;
            end
            if (wait_n == 0) begin
                req_seen = 0;
                chk(mem_addr == held_addr, "R7 address held", mem_addr, held_addr);
                chk(mem_stride == AW'(es), "R2 stride", mem_stride, es);
                if (mem_we) begin
                    chk(int'(mem_addr) == ((ezb + zo*8*es) & 16'hFFFF), "R2 Z octet addr", mem_addr, ezb + zo*8*es);
                    for (int i = 0; i < 8; i++)
                        if (mem_wmask[i]) mm[(mem_addr + i*es) & 1023] = mem_wdata[i*W +: W];
                    zo++; wrs++;
                end else begin
                    if (first_rd < 0) first_rd = mem_addr;
                    if (int'(mem_addr) == ((exb + xo*8*es) & 16'hFFFF)) xo++;
                    else if (int'(mem_addr) == ((eyb + yo*8*es) & 16'hFFFF)) yo++;
                    else chk(0, "R2 read addr", mem_addr, exb + xo*8*es);
                    for (int i = 0; i < 8; i++) mem_rdata[i*W +: W] = mm[(mem_addr + i*es) & 1023];
                    rds++;
                end
                mem_ack = 1;
            end else wait_n--;
        end
        op_ready = au_en && lfsr[2];
        if (op_valid && op_ready) begin
            chk(op_x == ex_x[pair_k], "R3 X operand", op_x, ex_x[pair_k]);
            chk(op_y == ex_y[pair_k], "R3 Y operand", op_y, ex_y[pair_k]);
            rq[qt & 255] = op_x + op_y; qt++; pair_k++;
        end
        res_valid = (qh < qt) && lfsr[3];
        res_data  = rq[qh & 255];
        if (res_valid && res_ready) begin last_res = res_data; qh++; end
    end

    task automatic prep(input int xb, yb, zb, s);
        init_mem();
        exb = xb; eyb = yb; ezb = zb; es = s;
        xo = 0; yo = 0; zo = 0; rds = 0; wrs = 0; pair_k = 0; qh = 0; qt = 0; first_rd = -1;
    endtask

    task automatic wait_done(input int d0, input string tag);
        int t = 0;
        while (done_cnt == d0 && t < 4000) begin @(negedge clk); t++; end
        chk(done_cnt == d0 + 1, tag, done_cnt - d0, 1);
    endtask

    task automatic run_vec(input int xb, yb, zb, s, n, stall, bit poke);
        int d0 = done_cnt, oc = (n + 7) / 8;
        prep(xb, yb, zb, s);
        for (int k = 0; k < n; k++) begin ex_x[k] = ival(xb + k*s); ex_y[k] = ival(yb + k*s); end
        if (stall > 0) au_en = 0;
        @(negedge clk);
        v_xbase = AW'(xb); v_ybase = AW'(yb); v_zbase = AW'(zb); v_stride = AW'(s); v_count = CW'(n);
        v_start = 1;
        @(negedge clk); v_start = 0;
        if (stall > 0) begin
            repeat (stall) @(negedge clk);
            chk(rds == 4, "R5 look-ahead reads", rds, 4);
            chk(first_rd == xb, "R6 tie goes to X", first_rd, xb);
            chk(pair_k == 0, "R5 no pair consumed", pair_k, 0);
            au_en = 1;
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            v_zbase = 16'd700; v_count = 5; v_start = 1; s_start = 1; s_zaddr = 16'd720;
            @(negedge clk); v_start = 0; s_start = 0;
        end
        wait_done(d0, "R10 done after run");
        for (int k = 0; k < n; k++)
            chk(mm[(zb + k*s) & 1023] == 16'(ex_x[k] + ex_y[k]), "R4 stored result", mm[(zb + k*s) & 1023], 16'(ex_x[k] + ex_y[k]));
        for (int k = n; k < oc*8; k++)
            chk(mm[(zb + k*s) & 1023] == ival(zb + k*s), "R4 masked lane untouched", mm[(zb + k*s) & 1023], ival(zb + k*s));
        chk(rds == 2*oc, "R2 read count", rds, 2*oc);
        chk(wrs == oc, "R2 write count", wrs, oc);
        if (poke)
            for (int j = 0; j < 24; j++)
                chk(mm[700 + j] == ival(700 + j), "R11 start while busy ignored", mm[700 + j], ival(700 + j));
        repeat (3) @(negedge clk);
        chk(done_cnt == d0 + 1, "R10 single pulse", done_cnt - d0, 1);
    endtask

    task automatic run_sc(input bit xf, yf, input int xa, ya, za);
        int d0 = done_cnt;
        logic [15:0] sum;
        prep(xa, ya, za, 1);
        ex_x[0] = xf ? last_res : ival(xa);
        ex_y[0] = yf ? last_res : ival(ya);
        sum = ex_x[0] + ex_y[0];
        @(negedge clk);
        s_xfwd = xf; s_yfwd = yf; s_xaddr = AW'(xa); s_yaddr = AW'(ya); s_zaddr = AW'(za); s_start = 1;
        @(negedge clk); s_start = 0;
        wait_done(d0, "R8 scalar done");
        chk(mm[za] == sum, "R8 scalar result", mm[za], sum);
        chk(mm[za + 1] == ival(za + 1), "R8 single lane mask", mm[za + 1], ival(za + 1));
        chk(rds == int'(!xf) + int'(!yf), "R9 reads with forwarding", rds, int'(!xf) + int'(!yf));
        chk(wrs == 1, "R8 one store", wrs, 1);
    endtask

    initial begin
        init_mem(); es = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
        chk(!mem_req, "R1 reset mem_req", mem_req, 0);
        chk(!op_valid && !res_ready, "R1 R12 reset handshakes", {op_valid, res_ready}, 0);
        run_vec(0, 256, 512, 1, 24, 80, 0);
        for (int s = 1; s <= 3; s++)
            for (int n = 1; n <= 17; n++)
                run_vec(s * 4, 256 + s, 512 + n, s, n, 0, 0);
        run_vec(10, 300, 520, 2, 12, 0, 1);
        @(negedge clk); v_count = 0; v_start = 1;
        @(negedge clk); v_start = 0;
        @(negedge clk);
        chk(!busy, "R11 zero count ignored", busy, 0);
        run_sc(0, 0, 5, 300, 600);
        run_sc(1, 0, 9, 301, 610);
        run_sc(1, 1, 9, 302, 620);
        chk(!res_ready, "R12 res_ready low when idle", res_ready, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule